// File: doc/BRIEF.md
# Seven-to-one parallel-to-serial link transmitter

The block turns a 28-bit parallel word, presented once per pixel-clock period, into four serial data lanes that each run at seven times the pixel rate. A fifth lane sends a forwarded clock that runs at the pixel rate. It is built from the same seven-bit slicing as the data lanes, so it keeps a fixed phase relation to the data slices. The fast bit clock is supplied from outside the block and is phase aligned with the pixel clock. A pixel-clock rising edge coincides with a bit-clock rising edge. Clock multiplication and differential line drivers sit outside the block, and all outputs are single-ended logic levels.

The parallel bus can be captured on either edge of the pixel clock. An active-low shutdown input clears every register asynchronously, silences all lanes and drops the lane-enable output. After shutdown is released, the bit-clock side waits for a genuine pixel-clock rising edge. It must see the pixel clock low first. From that edge it derives the slice boundary, so serial output begins on a whole, freshly captured word, whatever the point in the pixel period at which the release happens.

Top module: `pix_serial_tx`

## Requirements
- R1: Parallel bit n is sent on lane n/7, in slot n%7 of the slice. Slot 0 leaves first, so inside each lane the lowest-numbered bit goes out first.
- R2: While the latched edge select is 1, the word on the bus at a pixel-clock rising edge is the one that is serialized.
- R3: While the latched edge select is 0, the word on the bus at a pixel-clock falling edge is the one that is serialized.
- R4: Consecutive captured words leave back to back. Each pixel period carries exactly one slice per lane, with no idle slots between slices once enabled.
- R5: During every enabled slice, the clock lane sends the slots 0..6 as 1,1,0,0,0,1,1. This gives a forwarded clock with a high time of four bit periods and a low time of three.
- R6: While shutdown is low, all data lanes, the clock lane and the lane enable are 0. This takes effect asynchronously, without waiting for a clock edge.
- R7: Shutdown clears the capture and shift registers, so the first slice after release carries a word captured after that release and never stale data.
- R8: Let P be the first pixel-clock rising edge after release that follows an observed low level of the pixel clock. Lanes and lane enable stay 0 until the bit-clock edge seven bit periods after P. At that edge the lane enable goes to 1 and stays there, and slot 0 of the first slice appears.
- R9: The edge select is sampled only while the lane enable is low. Changing it while the lanes are enabled has no effect on which words are sent.
- R10: The slice alignment of R8 holds whatever the release point within the pixel period, including a release while the pixel clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock, seven times the pixel rate, rising edges aligned to pixel-clock rising edges |
| pixClk | input | 1 | Pixel clock |
| shutdownN | input | 1 | Active-low shutdown and asynchronous clear |
| edgeRise | input | 1 | Capture edge select: 1 rising, 0 falling |
| parWord | input | 28 | Parallel input word |
| laneData | output | 4 | Serial data lanes, one bit each |
| laneClk | output | 1 | Forwarded clock lane |
| laneEn | output | 1 | Lane driver enable |

## Verification
The hardest situation to reach is a shutdown release that lands part way through a pixel period, in particular while the pixel clock is already high. A careless phase detector would then lock onto a false edge and shift every slice. The bench releases shutdown at slot offsets 0, 2 and 5 of a pixel period, under both capture-edge settings. It then deserializes every lane and checks the exact bit-clock edge where the lane enable rises and the first recovered word. In two of the runs the edge select is flipped mid-stream, to show that the sending continues unchanged.

// File: rtl/ptx_pkg.sv
`timescale 1ns/100ps
package ptx_pkg;
  // default geometry: four data lanes, seven bits per slice
  localparam int LANES_DEF = 4;
  localparam int SLICE_DEF = 7;
  // forwarded clock slots, bit index = slot number (slot 0 sent first)
  localparam logic [SLICE_DEF-1:0] FWD_CLK_DEF = 7'b1100011;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // slice boundary: move capture word into shifters
    logic active;   // lanes are enabled
    logic selRise;  // latched capture edge select
  } ctlStrobe_t;
endpackage

// File: rtl/ptx_lane_shift.sv
`timescale 1ns/100ps
module ptx_lane_shift #(
  parameter int SLICE = 7
) (
  input  logic             bitClk,
  input  logic             shutdownN,
  input  logic             load,
  input  logic [SLICE-1:0] loadVal,
  output logic             serOut
);
  logic [SLICE-1:0] shiftReg;

  // slot 0 in the low bit leaves first; shift toward bit 0
  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      shiftReg <= '0;
    end else if (load) begin
      shiftReg <= loadVal;
    end else begin
      shiftReg <= {1'b0, shiftReg[SLICE-1:1]};
    end
  end

  assign serOut = shiftReg[0];
endmodule

// File: rtl/ptx_ctrl.sv
`timescale 1ns/100ps
module ptx_ctrl
  import ptx_pkg::*;
#(
  parameter int SLICE = 7
) (
  input  logic       bitClk,
  input  logic       pixClk,
  input  logic       shutdownN,
  input  logic       edgeRise,
  output ctlStrobe_t strb
);
  localparam int CW = (SLICE > 1) ? $clog2(SLICE) : 1;
  localparam logic [CW-1:0] LAST  = CW'(SLICE - 1);
  localparam logic [CW-1:0] FIRST = CW'(1);

  logic          pixSamp;   // pixel clock seen mid bit period
  logic          pixPrev;   // previous mid-bit sample
  logic          locked;    // slice phase known
  logic          active;    // first slice has been loaded
  logic          selRise;   // latched capture edge select
  logic [CW-1:0] phase;     // slot index of the current bit period

  // sample the pixel clock half a bit period away from its edges
  always_ff @(negedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      pixSamp <= 1'b1;
    end else begin
      pixSamp <= pixClk;
    end
  end

  // phase tracking: a rise needs a low sample first, so reset both to 1
  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      pixPrev <= 1'b1;
      locked  <= 1'b0;
      active  <= 1'b0;
      phase   <= '0;
    end else begin
      pixPrev <= pixSamp;
      if (!locked) begin
        // rise seen one bit after the pixel edge, so this period is slot 1
        if (pixSamp && !pixPrev) begin
          locked <= 1'b1;
          phase  <= FIRST;
        end
      end else begin
        if (phase == LAST) begin
          phase  <= '0;
          active <= 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // edge select follows the pin only while the lanes are still disabled
  always_ff @(posedge bitClk) begin
    if (!active) begin
      selRise <= edgeRise;
    end
  end

  always_comb begin
    strb.load    = locked && (phase == LAST);
    strb.active  = active;
    strb.selRise = selRise;
  end
endmodule

// File: rtl/ptx_datapath.sv
`timescale 1ns/100ps
module ptx_datapath
  import ptx_pkg::*;
#(
  parameter int               LANES       = 4,
  parameter int               SLICE       = 7,
  parameter logic [SLICE-1:0] FWD_CLK_PAT = 7'b1100011
) (
  input  logic                   bitClk,
  input  logic                   pixClk,
  input  logic                   shutdownN,
  input  logic [LANES*SLICE-1:0] parWord,
  input  ctlStrobe_t             strb,
  output logic [LANES-1:0]       laneData,
  output logic                   laneClk,
  output logic                   laneEn
);
  localparam int WORD_W = LANES * SLICE;

  logic [WORD_W-1:0] capRise;
  logic [WORD_W-1:0] capFall;
  logic [WORD_W-1:0] capWord;

  always_ff @(posedge pixClk or negedge shutdownN) begin
    if (!shutdownN) begin
      capRise <= '0;
    end else begin
      capRise <= parWord;
    end
  end

  always_ff @(negedge pixClk or negedge shutdownN) begin
    if (!shutdownN) begin
      capFall <= '0;
    end else begin
      capFall <= parWord;
    end
  end

  // select is static while the shifters are loading
  assign capWord = strb.selRise ? capRise : capFall;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ptx_lane_shift #(.SLICE(SLICE)) u_shift (
      .bitClk   (bitClk),
      .shutdownN(shutdownN),
      .load     (strb.load),
      .loadVal  (capWord[l*SLICE +: SLICE]),
      .serOut   (laneData[l])
    );
  end

  // forwarded clock is just another lane with a constant slice
  ptx_lane_shift #(.SLICE(SLICE)) u_clkShift (
    .bitClk   (bitClk),
    .shutdownN(shutdownN),
    .load     (strb.load),
    .loadVal  (FWD_CLK_PAT),
    .serOut   (laneClk)
  );

  assign laneEn = strb.active;
endmodule

// File: rtl/pix_serial_tx.sv
`timescale 1ns/100ps
module pix_serial_tx
  import ptx_pkg::*;
#(
  parameter int               LANES       = LANES_DEF,
  parameter int               SLICE       = SLICE_DEF,
  parameter logic [SLICE-1:0] FWD_CLK_PAT = FWD_CLK_DEF
) (
  input  logic                   bitClk,
  input  logic                   pixClk,
  input  logic                   shutdownN,
  input  logic                   edgeRise,
  input  logic [LANES*SLICE-1:0] parWord,
  output logic [LANES-1:0]       laneData,
  output logic                   laneClk,
  output logic                   laneEn
);
  ctlStrobe_t strb;

  ptx_ctrl #(.SLICE(SLICE)) u_ctrl (
    .bitClk   (bitClk),
    .pixClk   (pixClk),
    .shutdownN(shutdownN),
    .edgeRise (edgeRise),
    .strb     (strb)
  );

  ptx_datapath #(
    .LANES      (LANES),
    .SLICE      (SLICE),
    .FWD_CLK_PAT(FWD_CLK_PAT)
  ) u_dp (
    .bitClk   (bitClk),
    .pixClk   (pixClk),
    .shutdownN(shutdownN),
    .parWord  (parWord),
    .strb     (strb),
    .laneData (laneData),
    .laneClk  (laneClk),
    .laneEn   (laneEn)
  );
endmodule

// File: rtl/ptx_checker.sv
`timescale 1ns/100ps
module ptx_checker #(
  parameter int               LANES       = 4,
  parameter int               SLICE       = 7,
  parameter logic [SLICE-1:0] FWD_CLK_PAT = 7'b1100011
) (
  input logic             bitClk,
  input logic             shutdownN,
  input logic [LANES-1:0] laneData,
  input logic             laneClk,
  input logic             laneEn
);
  localparam int CW = (SLICE > 1) ? $clog2(SLICE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLICE - 1);

  logic [CW-1:0] slotCnt;

  // slot counter observed from the lane enable only
  always_ff @(posedge bitClk or negedge shutdownN) begin
    if (!shutdownN) begin
      slotCnt <= '0;
    end else if (laneEn) begin
      slotCnt <= (slotCnt == LAST) ? '0 : slotCnt + 1'b1;
    end
  end

  // R8: nothing leaves before the lanes are enabled
  a_r8_quiet_until_enable: assert property (@(posedge bitClk) disable iff (!shutdownN)
    !laneEn |-> ((laneData == '0) && !laneClk));

  // R8: once enabled, the lanes stay enabled until shutdown
  a_r8_enable_holds: assert property (@(posedge bitClk) disable iff (!shutdownN)
    laneEn |=> laneEn);

  // R5: forwarded clock follows the slot pattern
  a_r5_clock_pattern: assert property (@(posedge bitClk) disable iff (!shutdownN)
    laneEn |-> (laneClk == FWD_CLK_PAT[slotCnt]));

  // R6: dark while in shutdown
  always @(negedge bitClk) begin
    if (shutdownN === 1'b0) begin
      a_r6_dark_in_shutdown: assert ((laneData == '0) && !laneClk && !laneEn);
    end
  end
endmodule

bind pix_serial_tx ptx_checker #(
  .LANES      (LANES),
  .SLICE      (SLICE),
  .FWD_CLK_PAT(FWD_CLK_PAT)
) chk_i (
  .bitClk   (bitClk),
  .shutdownN(shutdownN),
  .laneData (laneData),
  .laneClk  (laneClk),
  .laneEn   (laneEn)
);

// File: tb/pix_serial_tx_tb_top.sv
`timescale 1ns/100ps
module pix_serial_tx_tb_top;
  localparam int LANES  = 4;
  localparam int SLICE  = 7;
  localparam int WORD_W = LANES * SLICE;
  localparam int NWORDS = 32;
  localparam logic [SLICE-1:0] CLK_EXP = 7'b1100011;

  logic              bitClk;
  logic              pixClk;
  logic              shutdownN;
  logic              edgeRise;
  logic [WORD_W-1:0] parWord;
  logic [LANES-1:0]  laneData;
  logic              laneClk;
  logic              laneEn;

  int edgeIdx;
  int checks;
  int failures;

  pix_serial_tx dut_i (
    .bitClk   (bitClk),
    .pixClk   (pixClk),
    .shutdownN(shutdownN),
    .edgeRise (edgeRise),
    .parWord  (parWord),
    .laneData (laneData),
    .laneClk  (laneClk),
    .laneEn   (laneEn)
  );

  // 200 MHz bit clock; pixel clock rises with every seventh bit edge, high four bits
  initial begin
    bitClk  = 1'b0;
    pixClk  = 1'b0;
    edgeIdx = -1;
    forever begin
      for (int k = 0; k < SLICE; k++) begin
        edgeIdx = edgeIdx + 1;
        bitClk  = 1'b1;
        if (k == 0) pixClk = 1'b1;
        if (k == 4) pixClk = 1'b0;
        #2.5;
        bitClk = 1'b0;
        #2.5;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, exp, edgeIdx);
    end
  endtask

  task automatic waitEdge(input int e);
    while (edgeIdx < e) @(posedge bitClk);
  endtask

  function automatic logic [WORD_W-1:0] wordOf(input int run, input int n);
    logic [31:0] h;
    if (n < WORD_W) return WORD_W'(1) << ((n + run * 3) % WORD_W);
    if (n == WORD_W) return '1;
    if (n == WORD_W + 1) return '0;
    h = 32'(n) * 32'h9E3779B1 + 32'(run) * 32'h7F4A7C15;
    return h[WORD_W-1:0] ^ WORD_W'(h >> 5);
  endfunction

  // one shutdown/release/stream/shutdown cycle
  task automatic runCase(input int run, input bit rise, input int off, input bit flipSel);
    int base;
    int r0;
    int shift;
    logic [WORD_W-1:0] got;
    logic [WORD_W-1:0] exp;
    logic [SLICE-1:0]  clkBits;
    string tag;

    shutdownN = 1'b0;
    edgeRise  = rise;
    parWord   = wordOf(run, 0);
    repeat (3) @(posedge bitClk);
    @(negedge bitClk);
    // R6: dark during shutdown
    checkEq("R6", {28'd0, laneEn, laneClk, |laneData}, 32'd0);

    base = (edgeIdx / SLICE + 1) * SLICE;
    r0   = base + SLICE;
    shift = rise ? 0 : 1;
    waitEdge(base + off);
    #0.5;
    shutdownN = 1'b1;

    fork
      begin
        for (int n = 1; n < NWORDS + 2; n++) begin
          waitEdge(base + SLICE * n + 2);
          #1;
          parWord = wordOf(run, n);
        end
      end
      begin
        waitEdge(r0 + SLICE - 1);
        @(negedge bitClk);
        // R8: still disabled one bit before the first slice
        checkEq("R8", {27'd0, laneEn, laneClk, laneData}, 32'd0);
        for (int j = 0; j < NWORDS - 1; j++) begin
          got = '0;
          clkBits = '0;
          for (int b = 0; b < SLICE; b++) begin
            waitEdge(r0 + SLICE + SLICE * j + b);
            @(negedge bitClk);
            if (j == 0 && b == 0) checkEq("R8", {31'd0, laneEn}, 32'd1);
            for (int l = 0; l < LANES; l++) got[l*SLICE + b] = laneData[l];
            clkBits[b] = laneClk;
            if (flipSel && j == 5 && b == 3) edgeRise = !rise;
          end
          exp = wordOf(run, j + shift);
          if (j == 0) tag = "R7";
          else if (flipSel && j > 5) tag = "R9";
          else if (off != 0) tag = "R10";
          else if (j % 2 == 1) tag = "R4";
          else tag = rise ? "R2" : "R3";
          checkEq(tag, {4'd0, got}, {4'd0, exp});
          // R5: forwarded clock slots
          checkEq("R5", {25'd0, clkBits}, {25'd0, CLK_EXP});
          if ((j + shift) < WORD_W) begin
            for (int l = 0; l < LANES; l++) begin
              // R1: per-lane slice of a walking one
              checkEq("R1", {25'd0, got[l*SLICE +: SLICE]}, {25'd0, exp[l*SLICE +: SLICE]});
            end
          end
        end
      end
    join

    // R6: asynchronous shutdown in mid bit
    #1;
    shutdownN = 1'b0;
    #0.5;
    checkEq("R6", {28'd0, laneEn, laneClk, |laneData}, 32'd0);
    repeat (SLICE + 2) @(negedge bitClk);
    checkEq("R6", {28'd0, laneEn, laneClk, |laneData}, 32'd0);
  endtask

  initial begin
    #100000;
    failures = failures + 1;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    checks    = 0;
    failures  = 0;
    shutdownN = 1'b0;
    edgeRise  = 1'b1;
    parWord   = '0;
    repeat (2) @(negedge bitClk);
    // R6: reset state
    checkEq("R6", {27'd0, laneEn, laneClk, laneData}, 32'd0);
    runCase(0, 1'b1, 0, 1'b1);
    runCase(1, 1'b0, 2, 1'b0);
    runCase(2, 1'b1, 5, 1'b0);
    runCase(3, 1'b0, 0, 1'b1);
    summary();
  end
endmodule